// File: doc/BRIEF.md
# Serial-Memory Pin Routing Matrix

This block sits between two octal serial-memory controllers and two external pin ports. Each port has one configuration register. For each of five signal groups, the register picks a source controller and holds an enable bit. The five groups are the upper data nibble, the lower data nibble, the chip select, the data strobe and the clock pair. The outputs, the output enables and the returning inputs are all steered by combinational multiplexers. A change of register contents therefore takes effect on the next cycle without a pipeline stage. The same settings also steer the inputs returning from the pads back to the controller that owns each group.

A control register holds a single mode bit, which selects multiplexed mode. In this mode an external arbiter supplies one shared bus. Data nibbles, strobe and clocks then come from that bus and no longer come from a controller. Chip selects always come straight from a controller. Configuration can change only while both controllers report that they are disabled. A write attempted at any other time is dropped, and it sets a sticky error output.

Top module: `spim_pin_matrix`

## Requirements
- R1: After reset, the control register reads 0x00000000, port 1 reads 0x03010111 and port 2 reads 0x07050333. The port register fields are:
  - upper-nibble source in bits 26:25 and its enable in bit 24;
  - lower-nibble source in bits 18:17 and its enable in bit 16;
  - chip-select source in bit 9 and its enable in bit 8;
  - strobe source in bit 5 and its enable in bit 4;
  - clock source in bit 1 and its enable in bit 0.
- R2: The control register sits at byte offset 0, with the multiplexed-mode bit at bit 0. The port 1 register sits at offset 4 and the port 2 register at offset 8. Read data appears one cycle after the address is presented. Reserved bits read 0. Any other offset, misaligned offsets included, reads 0.
- R3: A write takes effect only while `ctl_active` is 0. A write made while any `ctl_active` bit is 1 leaves every register unchanged and sets `cfg_err`, which stays set until reset.
- R4: In non-multiplexed mode, an enabled nibble with source code 00 takes controller 1 IO[3:0]. Code 01 takes controller 1 IO[7:4], code 10 takes controller 2 IO[3:0] and code 11 takes controller 2 IO[7:4]. The output enables follow the same selection.
- R5: In multiplexed mode, nibble code 00 takes shared-bus bits 3:0 and code 01 takes shared-bus bits 7:4. Codes 10 and 11 leave the nibble inactive.
- R6: A disabled or unused group drives these inactive values, each with its output enable low:
  - data 0;
  - clock 0;
  - inverted clock 1;
  - strobe 0;
  - chip select 1.
- R7: Chip-select source 0 selects controller 1 and source 1 selects controller 2, in both modes. An enabled chip select drives its output enable high.
- R8: Clock and strobe source 0 selects controller 1, or the shared bus in multiplexed mode. Source 1 selects controller 2, or leaves the group inactive in multiplexed mode. An enabled clock drives its enable high. An enabled strobe passes on the output enable of its source.
- R9: Each controller nibble receives the pad input of the lowest-numbered port whose enabled nibble selects that code. Within one port, the lower nibble takes precedence. An unrouted nibble reads 0. In multiplexed mode every controller data input reads 0, and the shared-bus input gets codes 00 and 01.
- R10: Each controller strobe input receives the pad strobe of the lowest-numbered port routing that source, or 0 when no port routes it. In multiplexed mode, source 0 feeds the shared-bus strobe input and both controller strobe inputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| cfg_err | output | 1 | Sticky flag for a locked write |
| ctl_active | input | 2 | Per-controller enabled status |
| ctl_clk | input | 2 | Controller clocks |
| ctl_clk_n | input | 2 | Controller inverted clocks |
| ctl_cs_n | input | 2 | Controller chip selects |
| ctl_dqs_o | input | 2 | Controller strobe out |
| ctl_dqs_oe | input | 2 | Controller strobe enable |
| ctl_dqs_i | output | 2 | Strobe returned to controllers |
| ctl_io_o | input | 16 | Controller data out, 8 bits per controller |
| ctl_io_oe | input | 16 | Controller data enables |
| ctl_io_i | output | 16 | Data returned to controllers |
| shr_clk | input | 1 | Shared-bus clock |
| shr_clk_n | input | 1 | Shared-bus inverted clock |
| shr_dqs_o | input | 1 | Shared-bus strobe out |
| shr_dqs_oe | input | 1 | Shared-bus strobe enable |
| shr_dqs_i | output | 1 | Strobe returned to the shared bus |
| shr_io_o | input | 8 | Shared-bus data out |
| shr_io_oe | input | 8 | Shared-bus data enables |
| shr_io_i | output | 8 | Data returned to the shared bus |
| pad_clk | output | 2 | Port clocks |
| pad_clk_n | output | 2 | Port inverted clocks |
| pad_clk_oe | output | 2 | Port clock enables |
| pad_cs_n | output | 2 | Port chip selects |
| pad_cs_oe | output | 2 | Port chip-select enables |
| pad_dqs_o | output | 2 | Port strobe out |
| pad_dqs_oe | output | 2 | Port strobe enables |
| pad_dqs_i | input | 2 | Port strobe in |
| pad_io_o | output | 16 | Port data out, 8 bits per port |
| pad_io_oe | output | 16 | Port data enables |
| pad_io_i | input | 16 | Port data in |

## Verification
The only stored state is the set of configuration fields and the mode bit. Every routing path reads that state combinationally, so a corrupted field shows up on the pads in the first cycle after the faulty write. It appears as a nibble from the wrong controller, a group left inactive, or data returned to the wrong controller. The bench drives a distinct value into each nibble so that any swap can be seen, and it reads every register back one cycle after each write. A lost lock shows up as a changed read-back together with `cfg_err` staying low.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int NPORT = 2;
  localparam int NCTL  = 2;
  localparam int REG_W = 32;
  localparam int LANE  = 8;
  localparam int NIB   = 4;

  localparam logic [REG_W-1:0] PORT_WMASK = 32'h0707_0333;
  localparam logic [REG_W-1:0] MODE_WMASK = 32'h0000_0001;
  localparam logic [REG_W-1:0] PORT0_INIT = 32'h0301_0111;
  localparam logic [REG_W-1:0] PORT1_INIT = 32'h0705_0333;

  typedef struct packed {
    logic [1:0] src;
    logic       en;
  } nib_cfg_t;

  typedef struct packed {
    nib_cfg_t hi;
    nib_cfg_t lo;
    logic     cs_src;
    logic     cs_en;
    logic     dqs_src;
    logic     dqs_en;
    logic     clk_src;
    logic     clk_en;
  } port_cfg_t;

  function automatic port_cfg_t word_to_cfg(input logic [REG_W-1:0] w);
    port_cfg_t c;
    logic [REG_W-1:0] m;
    m = w & PORT_WMASK;
    c.hi.src  = m[26:25];
    c.hi.en   = m[24];
    c.lo.src  = m[18:17];
    c.lo.en   = m[16];
    c.cs_src  = m[9];
    c.cs_en   = m[8];
    c.dqs_src = m[5];
    c.dqs_en  = m[4];
    c.clk_src = m[1];
    c.clk_en  = m[0];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] cfg_to_word(input port_cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[26:25] = c.hi.src;
    w[24]    = c.hi.en;
    w[18:17] = c.lo.src;
    w[16]    = c.lo.en;
    w[9]     = c.cs_src;
    w[8]     = c.cs_en;
    w[5]     = c.dqs_src;
    w[4]     = c.dqs_en;
    w[1]     = c.clk_src;
    w[0]     = c.clk_en;
    return w;
  endfunction
endpackage

// File: rtl/spim_cfg_regs.sv
module spim_cfg_regs
  import spim_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [REG_W-1:0]      wdata,
  input  logic [NCTL-1:0]       ctl_active,
  output logic [REG_W-1:0]      rdata,
  output logic                  mux_mode,
  output port_cfg_t [NPORT-1:0] pcfg,
  output logic                  err
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             locked;
  logic             wr_ok;
  logic [REG_W-1:0] rd_next;

  assign idx     = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign locked  = |ctl_active;
  assign wr_ok   = we && !locked && aligned;

  always_ff @(posedge clk) begin
    if (rst) begin
      mux_mode <= 1'b0;
    end else if (wr_ok && idx == '0) begin
      mux_mode <= |(wdata & MODE_WMASK);
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam logic [REG_W-1:0] INIT = (p == 0) ? PORT0_INIT : PORT1_INIT;
    always_ff @(posedge clk) begin
      if (rst) begin
        pcfg[p] <= word_to_cfg(INIT);
      end else if (wr_ok && idx == IDX_W'(p + 1)) begin
        pcfg[p] <= word_to_cfg(wdata);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err <= 1'b0;
    end else if (we && locked) begin
      err <= 1'b1;
    end
  end

  always_comb begin
    rd_next = '0;
    if (aligned) begin
      if (idx == '0) begin
        rd_next = {{(REG_W-1){1'b0}}, mux_mode};
      end
      for (int p = 0; p < NPORT; p++) begin
        if (idx == IDX_W'(p + 1)) rd_next = cfg_to_word(pcfg[p]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/spim_port_route.sv
module spim_port_route
  import spim_pkg::*;
(
  input  port_cfg_t              cfg,
  input  logic                   mux_mode,
  input  logic [NCTL-1:0]        ctl_clk,
  input  logic [NCTL-1:0]        ctl_clk_n,
  input  logic [NCTL-1:0]        ctl_cs_n,
  input  logic [NCTL-1:0]        ctl_dqs_o,
  input  logic [NCTL-1:0]        ctl_dqs_oe,
  input  logic [NCTL*LANE-1:0]   ctl_io_o,
  input  logic [NCTL*LANE-1:0]   ctl_io_oe,
  input  logic                   shr_clk,
  input  logic                   shr_clk_n,
  input  logic                   shr_dqs_o,
  input  logic                   shr_dqs_oe,
  input  logic [LANE-1:0]        shr_io_o,
  input  logic [LANE-1:0]        shr_io_oe,
  output logic                   pad_clk,
  output logic                   pad_clk_n,
  output logic                   pad_clk_oe,
  output logic                   pad_cs_n,
  output logic                   pad_cs_oe,
  output logic                   pad_dqs_o,
  output logic                   pad_dqs_oe,
  output logic [LANE-1:0]        pad_io_o,
  output logic [LANE-1:0]        pad_io_oe
);
  logic clk_live;
  logic dqs_live;

  for (genvar g = 0; g < 2; g++) begin : g_nib
    nib_cfg_t nc;
    assign nc = (g == 1) ? cfg.hi : cfg.lo;
    always_comb begin
      pad_io_o[g*NIB +: NIB]  = '0;
      pad_io_oe[g*NIB +: NIB] = '0;
      if (nc.en) begin
        if (mux_mode) begin
          if (!nc.src[1]) begin
            pad_io_o[g*NIB +: NIB]  = shr_io_o[{nc.src[0], 2'b00} +: NIB];
            pad_io_oe[g*NIB +: NIB] = shr_io_oe[{nc.src[0], 2'b00} +: NIB];
          end
        end else begin
          pad_io_o[g*NIB +: NIB]  = ctl_io_o[{nc.src, 2'b00} +: NIB];
          pad_io_oe[g*NIB +: NIB] = ctl_io_oe[{nc.src, 2'b00} +: NIB];
        end
      end
    end
  end

  assign clk_live = cfg.clk_en && !(mux_mode && cfg.clk_src);
  assign dqs_live = cfg.dqs_en && !(mux_mode && cfg.dqs_src);

  always_comb begin
    pad_clk    = 1'b0;
    pad_clk_n  = 1'b1;
    pad_clk_oe = clk_live;
    if (clk_live) begin
      pad_clk   = mux_mode ? shr_clk   : ctl_clk[cfg.clk_src];
      pad_clk_n = mux_mode ? shr_clk_n : ctl_clk_n[cfg.clk_src];
    end
  end

  always_comb begin
    pad_dqs_o  = 1'b0;
    pad_dqs_oe = 1'b0;
    if (dqs_live) begin
      pad_dqs_o  = mux_mode ? shr_dqs_o  : ctl_dqs_o[cfg.dqs_src];
      pad_dqs_oe = mux_mode ? shr_dqs_oe : ctl_dqs_oe[cfg.dqs_src];
    end
  end

  assign pad_cs_n  = cfg.cs_en ? ctl_cs_n[cfg.cs_src] : 1'b1;
  assign pad_cs_oe = cfg.cs_en;
endmodule

// File: rtl/spim_return_sel.sv
module spim_return_sel
  import spim_pkg::*;
(
  input  nib_cfg_t [NPORT-1:0]     hi_cfg,
  input  nib_cfg_t [NPORT-1:0]     lo_cfg,
  input  logic [NPORT-1:0]         dqs_en,
  input  logic [NPORT-1:0]         dqs_src,
  input  logic                     mux_mode,
  input  logic [NPORT*LANE-1:0]    pad_io_i,
  input  logic [NPORT-1:0]         pad_dqs_i,
  output logic [NCTL*LANE-1:0]     ctl_io_i,
  output logic [NCTL-1:0]          ctl_dqs_i,
  output logic [LANE-1:0]          shr_io_i,
  output logic                     shr_dqs_i
);
  localparam int NCODE = NCTL * 2;

  logic [NCODE*NIB-1:0] code_val;
  logic [NCTL-1:0]      dqs_val;

  // Walk ports from highest to lowest so the lowest match is written last.
  always_comb begin
    code_val = '0;
    for (int k = 0; k < NCODE; k++) begin
      for (int p = NPORT - 1; p >= 0; p--) begin
        if (hi_cfg[p].en && hi_cfg[p].src == 2'(k))
          code_val[k*NIB +: NIB] = pad_io_i[p*LANE + NIB +: NIB];
        if (lo_cfg[p].en && lo_cfg[p].src == 2'(k))
          code_val[k*NIB +: NIB] = pad_io_i[p*LANE +: NIB];
      end
    end
  end

  always_comb begin
    dqs_val = '0;
    for (int s = 0; s < NCTL; s++) begin
      for (int p = NPORT - 1; p >= 0; p--) begin
        if (dqs_en[p] && dqs_src[p] == 1'(s)) dqs_val[s] = pad_dqs_i[p];
      end
    end
  end

  assign ctl_io_i  = mux_mode ? '0 : code_val;
  assign shr_io_i  = mux_mode ? code_val[LANE-1:0] : '0;
  assign ctl_dqs_i = mux_mode ? '0 : dqs_val;
  assign shr_dqs_i = mux_mode ? dqs_val[0] : 1'b0;
endmodule

// File: rtl/spim_pin_matrix.sv
module spim_pin_matrix
  import spim_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic                  cfg_err,
  input  logic [1:0]            ctl_active,
  input  logic [1:0]            ctl_clk,
  input  logic [1:0]            ctl_clk_n,
  input  logic [1:0]            ctl_cs_n,
  input  logic [1:0]            ctl_dqs_o,
  input  logic [1:0]            ctl_dqs_oe,
  output logic [1:0]            ctl_dqs_i,
  input  logic [15:0]           ctl_io_o,
  input  logic [15:0]           ctl_io_oe,
  output logic [15:0]           ctl_io_i,
  input  logic                  shr_clk,
  input  logic                  shr_clk_n,
  input  logic                  shr_dqs_o,
  input  logic                  shr_dqs_oe,
  output logic                  shr_dqs_i,
  input  logic [7:0]            shr_io_o,
  input  logic [7:0]            shr_io_oe,
  output logic [7:0]            shr_io_i,
  output logic [1:0]            pad_clk,
  output logic [1:0]            pad_clk_n,
  output logic [1:0]            pad_clk_oe,
  output logic [1:0]            pad_cs_n,
  output logic [1:0]            pad_cs_oe,
  output logic [1:0]            pad_dqs_o,
  output logic [1:0]            pad_dqs_oe,
  input  logic [1:0]            pad_dqs_i,
  output logic [15:0]           pad_io_o,
  output logic [15:0]           pad_io_oe,
  input  logic [15:0]           pad_io_i
);
  port_cfg_t [NPORT-1:0] pcfg;
  nib_cfg_t  [NPORT-1:0] hi_cfg;
  nib_cfg_t  [NPORT-1:0] lo_cfg;
  logic      [NPORT-1:0] dqs_en;
  logic      [NPORT-1:0] dqs_src;
  logic                  mux_mode;

  spim_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .ctl_active (ctl_active),
    .rdata      (reg_rdata),
    .mux_mode   (mux_mode),
    .pcfg       (pcfg),
    .err        (cfg_err)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_route
    assign hi_cfg[p]  = pcfg[p].hi;
    assign lo_cfg[p]  = pcfg[p].lo;
    assign dqs_en[p]  = pcfg[p].dqs_en;
    assign dqs_src[p] = pcfg[p].dqs_src;

    spim_port_route u_route (
      .cfg        (pcfg[p]),
      .mux_mode   (mux_mode),
      .ctl_clk    (ctl_clk),
      .ctl_clk_n  (ctl_clk_n),
      .ctl_cs_n   (ctl_cs_n),
      .ctl_dqs_o  (ctl_dqs_o),
      .ctl_dqs_oe (ctl_dqs_oe),
      .ctl_io_o   (ctl_io_o),
      .ctl_io_oe  (ctl_io_oe),
      .shr_clk    (shr_clk),
      .shr_clk_n  (shr_clk_n),
      .shr_dqs_o  (shr_dqs_o),
      .shr_dqs_oe (shr_dqs_oe),
      .shr_io_o   (shr_io_o),
      .shr_io_oe  (shr_io_oe),
      .pad_clk    (pad_clk[p]),
      .pad_clk_n  (pad_clk_n[p]),
      .pad_clk_oe (pad_clk_oe[p]),
      .pad_cs_n   (pad_cs_n[p]),
      .pad_cs_oe  (pad_cs_oe[p]),
      .pad_dqs_o  (pad_dqs_o[p]),
      .pad_dqs_oe (pad_dqs_oe[p]),
      .pad_io_o   (pad_io_o[p*LANE +: LANE]),
      .pad_io_oe  (pad_io_oe[p*LANE +: LANE])
    );
  end

  spim_return_sel u_ret (
    .hi_cfg    (hi_cfg),
    .lo_cfg    (lo_cfg),
    .dqs_en    (dqs_en),
    .dqs_src   (dqs_src),
    .mux_mode  (mux_mode),
    .pad_io_i  (pad_io_i),
    .pad_dqs_i (pad_dqs_i),
    .ctl_io_i  (ctl_io_i),
    .ctl_dqs_i (ctl_dqs_i),
    .shr_io_i  (shr_io_i),
    .shr_dqs_i (shr_dqs_i)
  );
endmodule

// File: rtl/spim_chk.sv
module spim_chk
  import spim_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  reg_we,
  input logic [ADDR_W-1:0]     reg_addr,
  input logic [31:0]           reg_rdata,
  input logic [1:0]            ctl_active,
  input logic                  cfg_err,
  input logic                  mux_mode,
  input port_cfg_t [NPORT-1:0] pcfg,
  input logic [15:0]           ctl_io_i,
  input logic [1:0]            pad_cs_n,
  input logic [1:0]            pad_cs_oe,
  input logic [1:0]            pad_clk,
  input logic [1:0]            pad_clk_oe
);
  // R3
  locked_write_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && |ctl_active) |=> cfg_err);

  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);

  // R3
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (|ctl_active) |=> ($stable(pcfg) && $stable(mux_mode)));

  // R6
  cs_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_cs_oe == 2'b00) |-> (pad_cs_n == 2'b11));

  // R6
  clk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_clk_oe == 2'b00) |-> (pad_clk == 2'b00));

  // R9
  mux_ctl_return_zero_chk: assert property (@(posedge clk) disable iff (rst)
    mux_mode |-> (ctl_io_i == 16'h0000));

  // R2
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !($past(reg_addr) == 0 || $past(reg_addr) == 4 || $past(reg_addr) == 8)
      |-> (reg_rdata == 32'h0));
endmodule

bind spim_pin_matrix spim_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .ctl_active (ctl_active),
  .cfg_err    (cfg_err),
  .mux_mode   (mux_mode),
  .pcfg       (pcfg),
  .ctl_io_i   (ctl_io_i),
  .pad_cs_n   (pad_cs_n),
  .pad_cs_oe  (pad_cs_oe),
  .pad_clk    (pad_clk),
  .pad_clk_oe (pad_clk_oe)
);

// File: tb/test_spim_pin_matrix.sv
`timescale 1ns/1ps
module test_spim_pin_matrix;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        cfg_err;
  logic [1:0]  ctl_active, ctl_clk, ctl_clk_n, ctl_cs_n, ctl_dqs_o, ctl_dqs_oe, ctl_dqs_i;
  logic [15:0] ctl_io_o, ctl_io_oe, ctl_io_i;
  logic        shr_clk, shr_clk_n, shr_dqs_o, shr_dqs_oe, shr_dqs_i;
  logic [7:0]  shr_io_o, shr_io_oe, shr_io_i;
  logic [1:0]  pad_clk, pad_clk_n, pad_clk_oe, pad_cs_n, pad_cs_oe;
  logic [1:0]  pad_dqs_o, pad_dqs_oe, pad_dqs_i;
  logic [15:0] pad_io_o, pad_io_oe, pad_io_i;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  spim_pin_matrix i_spim_pin_matrix (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 err after reset", 32'(cfg_err), 0);
    rd(4'h0, d); chk("R1 mode reg", d, 32'h0000_0000);
    rd(4'h4, d); chk("R1 port1 reg", d, 32'h0301_0111);
    rd(4'h8, d); chk("R1 port2 reg", d, 32'h0705_0333);
    ctl_io_o = 16'hA5C3; ctl_io_oe = 16'hF00F; pad_io_i = 16'h1234;
    #1;
    chk("R4 default data", 32'(pad_io_o), 32'hA5C3);
    chk("R4 default oe", 32'(pad_io_oe), 32'hF00F);
    chk("R9 default return", 32'(ctl_io_i), 32'h1234);
    ctl_dqs_o = 2'b10; ctl_dqs_oe = 2'b11; pad_dqs_i = 2'b01;
    #1;
    chk("R8 default dqs", 32'(pad_dqs_o), 32'h2);
    chk("R10 default dqs return", 32'(ctl_dqs_i), 32'h1);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, d); chk("R2 reserved bits zero", d, 32'h0707_0333);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R2 mode reserved zero", d, 32'h1);
    rd(4'hC, d); chk("R2 unmapped offset", d, 32'h0);
    rd(4'h6, d); chk("R2 misaligned offset", d, 32'h0);
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h0301_0111);
    rd(4'h4, d); chk("R2 restore port1", d, 32'h0301_0111);
  endtask

  task automatic t_locked;
    logic [31:0] d;
    ctl_active = 2'b10;
    wr(4'h4, 32'h0);
    wr(4'h0, 32'h1);
    chk("R3 err set", 32'(cfg_err), 1);
    rd(4'h4, d); chk("R3 port1 kept", d, 32'h0301_0111);
    rd(4'h0, d); chk("R3 mode kept", d, 32'h0);
    ctl_active = 2'b00;
    @(negedge clk);
    chk("R3 err sticky", 32'(cfg_err), 1);
  endtask

  task automatic t_swap;
    wr(4'h4, 32'h0507_0333);
    wr(4'h8, 32'h0);
    ctl_io_o = 16'hA5C3; ctl_io_oe = 16'hF00F; pad_io_i = 16'h1234;
    ctl_cs_n = 2'b01; ctl_clk = 2'b10; ctl_clk_n = 2'b01; pad_dqs_i = 2'b11;
    #1;
    chk("R4 swapped data", 32'(pad_io_o), 32'h005A);
    chk("R4 swapped oe / R6 disabled oe", 32'(pad_io_oe), 32'h000F);
    chk("R9 swapped return", 32'(ctl_io_i), 32'h4300);
    chk("R7 cs from ctl2 / R6 idle cs", 32'(pad_cs_n), 32'h2);
    chk("R6 cs oe", 32'(pad_cs_oe), 32'h1);
    chk("R8 clk from ctl2", 32'(pad_clk), 32'h1);
    chk("R6 idle nclk high", 32'(pad_clk_n), 32'h2);
    chk("R6 clk oe", 32'(pad_clk_oe), 32'h1);
    chk("R10 dqs return swapped", 32'(ctl_dqs_i), 32'h2);
  endtask

  task automatic t_mux;
    wr(4'h4, 32'h0301_0111);
    wr(4'h8, 32'h0705_0333);
    wr(4'h0, 32'h1);
    shr_io_o = 8'h6E; shr_io_oe = 8'hF0; shr_clk = 1'b1; shr_clk_n = 1'b0;
    shr_dqs_o = 1'b1; shr_dqs_oe = 1'b1;
    ctl_cs_n = 2'b01; pad_io_i = 16'h1234; pad_dqs_i = 2'b01;
    #1;
    chk("R5 shared data", 32'(pad_io_o), 32'h006E);
    chk("R5 shared oe", 32'(pad_io_oe), 32'h00F0);
    chk("R8 mux clk", 32'(pad_clk), 32'h1);
    chk("R8 mux nclk", 32'(pad_clk_n), 32'h2);
    chk("R8 mux clk oe", 32'(pad_clk_oe), 32'h1);
    chk("R7 mux cs direct", 32'(pad_cs_n), 32'h1);
    chk("R7 mux cs oe", 32'(pad_cs_oe), 32'h3);
    chk("R8 mux dqs", 32'(pad_dqs_o), 32'h1);
    chk("R8 mux dqs oe", 32'(pad_dqs_oe), 32'h1);
    chk("R9 shared return", 32'(shr_io_i), 32'h34);
    chk("R9 ctl return zero", 32'(ctl_io_i), 32'h0);
    chk("R10 shared dqs return", 32'(shr_dqs_i), 32'h1);
    chk("R10 ctl dqs zero", 32'(ctl_dqs_i), 32'h0);
    wr(4'h0, 32'h0);
  endtask

  task automatic t_overlap;
    wr(4'h8, 32'h0001_0000);
    ctl_io_o = 16'hA5C3; pad_io_i = 16'h1234;
    #1;
    chk("R9 lower port wins", 32'(ctl_io_i), 32'h0034);
    chk("R4 shared source data", 32'(pad_io_o), 32'h03C3);
    wr(4'h4, 32'h0300_0111);
    #1;
    chk("R9 fallback to port2", 32'(ctl_io_i), 32'h0032);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    ctl_active = '0; ctl_clk = '0; ctl_clk_n = '0; ctl_cs_n = '1;
    ctl_dqs_o = '0; ctl_dqs_oe = '0; ctl_io_o = '0; ctl_io_oe = '0;
    shr_clk = 1'b0; shr_clk_n = 1'b1; shr_dqs_o = 1'b0; shr_dqs_oe = 1'b0;
    shr_io_o = '0; shr_io_oe = '0; pad_dqs_i = '0; pad_io_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_reserved;
    t_locked;
    t_swap;
    t_mux;
    t_overlap;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule